// File: doc/BRIEF.md
# Configurable Eight-Bit GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a small register bus in a microcontroller-style subsystem. It keeps three 8-bit registers: an output latch, a per-pin input-mode register (analog or digital) and a per-pin output-mode register (open-drain or push-pull). Software can write any of them as a whole byte, or set or clear one bit of them. For every pin the block drives an output level, an output enable and a weak-pullup enable toward the pad. It also takes the sampled pin level back through a two-flop synchronizer.

Reads of the data register normally return the synchronized pin levels. The bus can raise a flag during the read phase of a read-modify-write instruction, such as AND, OR, XOR, complement, increment/decrement or a bit operation. While that flag is high the read returns the latch contents instead. An open-drain output pulled low from outside then cannot be written back as 0 by accident. A pin in analog mode always reads 0 and never gets its pullup. One global input turns off all weak pullups.

Top module: `gpio_octet`

## Requirements
- R1: After synchronous reset the output latch is 0xFF, the input-mode register is 0xFF (all digital) and the output-mode register is 0x00 (all open-drain). The synchronizer stages hold 0.
- R2: The register select `bus_sel` encodes 2'b00 = data latch, 2'b01 = input mode, 2'b10 = output mode. A cycle with `bus_wr` high loads `bus_wdata` into the selected register, and the new value is visible from the next cycle on.
- R3: A cycle with `bus_bit` high and `bus_wr` low writes `bus_bit_val` into bit `bus_bit_idx` of the selected register. All other bits are left unchanged.
- R4: When `bus_wr` and `bus_bit` are both high in the same cycle, the byte write wins and the bit operation is discarded.
- R5: With `bus_sel` = 2'b00 and `rmw_read` low, a digital pin's bit of `rd_data` equals the level seen on `pin_in` two rising edges earlier. `rd_data` is combinational from the registered state.
- R6: A pin whose input-mode bit is 0 (analog) reads 0 in a normal data read, whatever level is on the pin.
- R7: With `bus_sel` = 2'b00 and `rmw_read` high, `rd_data` returns the output latch, independent of pin levels and input modes.
- R8: An output-mode bit of 0 (open-drain) gives `pin_oe` = 1 with `pin_out` = 0 when the latch bit is 0. It gives `pin_oe` = 0 when the latch bit is 1.
- R9: An output-mode bit of 1 (push-pull) gives `pin_oe` = 1 with `pin_out` equal to the latch bit.
- R10: `pin_pu` is 1 for a pin only when it is digital, `pullup_off` is 0, and the pin is not being driven low (`pin_oe` = 1 with `pin_out` = 0).
- R11: `bus_sel` = 2'b11 selects no register. Writes and bit operations with it change nothing, and reads with it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_bit | input | 1 | Single-bit write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Byte write data |
| bus_bit_idx | input | 3 | Bit index for bit writes |
| bus_bit_val | input | 1 | Value written by a bit write |
| rmw_read | input | 1 | High during the read phase of a read-modify-write |
| pullup_off | input | 1 | Global weak-pullup disable |
| pin_in | input | 8 | Sampled pad levels |
| rd_data | output | 8 | Read data for the selected register |
| pin_out | output | 8 | Output level per pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Weak-pullup enable per pin |

## Verification
Two pairs of operations can land in one cycle. The first is a byte write together with a bit write to the same register. The bench drives both strobes at once with a bit value that disagrees with the byte data, and expects the byte to win. The second is a read-modify-write read of an open-drain pin that an outside source pulls low while its latch holds 1. The bench checks that the normal read shows 0, that the RMW read shows 1, and that writing the RMW result back leaves the latch and the released pad unchanged. Constrained random traffic with a fixed seed mixes both cases with mode changes and pin toggles. A bench reference model checks every cycle.

// File: rtl/gpio_octet_pkg.sv
package gpio_octet_pkg;

    localparam int unsigned PINS  = 8;
    localparam int unsigned IDX_W = $clog2(PINS);
    localparam int unsigned NREGS = 3;

    typedef logic [PINS-1:0] pin_vec_t;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'b00,
        SEL_IMODE = 2'b01,
        SEL_OMODE = 2'b10,
        SEL_NONE  = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic             byte_we;
        logic             bit_we;
        reg_sel_e         sel;
        pin_vec_t         wdata;
        logic [IDX_W-1:0] idx;
        logic             bval;
    } bus_req_t;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
    } pad_ctl_t;

    localparam pin_vec_t LATCH_RST = '1;
    localparam pin_vec_t IMODE_RST = '1;
    localparam pin_vec_t OMODE_RST = '0;

    function automatic pin_vec_t reg_next(
        input pin_vec_t         cur,
        input logic             byte_we,
        input logic             bit_we,
        input pin_vec_t         wdata,
        input logic [IDX_W-1:0] idx,
        input logic             bval
    );
        pin_vec_t n;
        n = cur;
        if (byte_we) begin
            n = wdata;
        end else if (bit_we) begin
            n[idx] = bval;
        end
        return n;
    endfunction

    function automatic pin_vec_t reset_of(input int unsigned which);
        case (which)
            0:       return LATCH_RST;
            1:       return IMODE_RST;
            default: return OMODE_RST;
        endcase
    endfunction

endpackage

// File: rtl/gpio_reg8.sv
module gpio_reg8
    import gpio_octet_pkg::*;
#(
    parameter pin_vec_t RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_we,
    input  logic             bit_we,
    input  pin_vec_t         wdata,
    input  logic [IDX_W-1:0] idx,
    input  logic             bval,
    output pin_vec_t         q
);

    pin_vec_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= RST_VAL;
        end else begin
            q_r <= reg_next(q_r, byte_we, bit_we, wdata, idx, bval);
        end
    end

    assign q = q_r;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage[0] <= '0;
        end else begin
            stage[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[s] <= '0;
            end else begin
                stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
    import gpio_octet_pkg::*;
(
    input  logic     latch_bit,
    input  logic     push_pull,
    input  logic     digital,
    input  logic     pullup_off,
    output pad_ctl_t ctl
);

    logic drive_low;

    always_comb begin
        if (push_pull) begin
            ctl.oe  = 1'b1;
            ctl.out = latch_bit;
        end else begin
            ctl.oe  = ~latch_bit;
            ctl.out = 1'b0;
        end
        drive_low = ctl.oe & ~ctl.out;
        ctl.pu    = digital & ~pullup_off & ~drive_low;
    end

endmodule

// File: rtl/gpio_octet.sv
module gpio_octet
    import gpio_octet_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_bit,
    input  logic [1:0]       bus_sel,
    input  logic [PINS-1:0]  bus_wdata,
    input  logic [IDX_W-1:0] bus_bit_idx,
    input  logic             bus_bit_val,
    input  logic             rmw_read,
    input  logic             pullup_off,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  rd_data,
    output logic [PINS-1:0]  pin_out,
    output logic [PINS-1:0]  pin_oe,
    output logic [PINS-1:0]  pin_pu
);

    bus_req_t req;
    pin_vec_t regs_q [NREGS];
    pin_vec_t latch_q, imode_q, omode_q;
    pin_vec_t pins_sync;

    always_comb begin
        req.byte_we = bus_wr;
        req.bit_we  = bus_bit;
        req.sel     = reg_sel_e'(bus_sel);
        req.wdata   = bus_wdata;
        req.idx     = bus_bit_idx;
        req.bval    = bus_bit_val;
    end

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        logic hit;
        assign hit = (req.sel == reg_sel_e'(r));
        gpio_reg8 #(
            .RST_VAL(reset_of(r))
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .byte_we(req.byte_we & hit),
            .bit_we (req.bit_we & hit),
            .wdata  (req.wdata),
            .idx    (req.idx),
            .bval   (req.bval),
            .q      (regs_q[r])
        );
    end

    assign latch_q = regs_q[0];
    assign imode_q = regs_q[1];
    assign omode_q = regs_q[2];

    gpio_sync #(
        .W     (PINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_in),
        .q  (pins_sync)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pad
        pad_ctl_t ctl;
        gpio_pad_cell u_cell (
            .latch_bit (latch_q[p]),
            .push_pull (omode_q[p]),
            .digital   (imode_q[p]),
            .pullup_off(pullup_off),
            .ctl       (ctl)
        );
        assign pin_out[p] = ctl.out;
        assign pin_oe[p]  = ctl.oe;
        assign pin_pu[p]  = ctl.pu;
    end

    always_comb begin
        case (req.sel)
            SEL_DATA:  rd_data = rmw_read ? latch_q : (pins_sync & imode_q);
            SEL_IMODE: rd_data = imode_q;
            SEL_OMODE: rd_data = omode_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_octet_chk.sv
module gpio_octet_chk
    import gpio_octet_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_bit,
    input logic [1:0]       bus_sel,
    input logic [PINS-1:0]  bus_wdata,
    input logic [IDX_W-1:0] bus_bit_idx,
    input logic             bus_bit_val,
    input logic             rmw_read,
    input logic             pullup_off,
    input logic [PINS-1:0]  rd_data,
    input logic [PINS-1:0]  pin_out,
    input logic [PINS-1:0]  pin_oe,
    input logic [PINS-1:0]  pin_pu,
    input logic [PINS-1:0]  latch_q,
    input logic [PINS-1:0]  imode_q,
    input logic [PINS-1:0]  omode_q
);

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (latch_q == '1 && imode_q == '1 && omode_q == '0));

    p_byte_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'b00) |=> (latch_q == $past(bus_wdata)));

    p_bit_wr_r3: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && bus_bit && bus_sel == 2'b00)
        |=> (latch_q[$past(bus_bit_idx)] == $past(bus_bit_val)));

    p_byte_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_bit && bus_sel == 2'b10) |=> (omode_q == $past(bus_wdata)));

    p_analog_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'b00 && !rmw_read) |-> ((rd_data & ~imode_q) == '0));

    p_rmw_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'b00 && rmw_read) |-> (rd_data == latch_q));

    p_od_release_r8: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~omode_q & latch_q) == '0));

    p_pp_enable_r9: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe | ~omode_q) == '1));

    p_pu_low_r10: assert property (@(posedge clk) disable iff (rst)
        ((pin_pu & pin_oe & ~pin_out) == '0));

    p_pu_off_r10: assert property (@(posedge clk) disable iff (rst)
        pullup_off |-> (pin_pu == '0));

    p_none_sel_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'b11 && (bus_wr || bus_bit))
        |=> ($stable(latch_q) && $stable(imode_q) && $stable(omode_q)));

endmodule

bind gpio_octet gpio_octet_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_bit    (bus_bit),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .bus_bit_idx(bus_bit_idx),
    .bus_bit_val(bus_bit_val),
    .rmw_read   (rmw_read),
    .pullup_off (pullup_off),
    .rd_data    (rd_data),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pin_pu     (pin_pu),
    .latch_q    (latch_q),
    .imode_q    (imode_q),
    .omode_q    (omode_q)
);

// File: tb/test_gpio_octet.sv
module test_gpio_octet;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_bit, bus_bit_val, rmw_read, pullup_off;
    logic [1:0] bus_sel;
    logic [7:0] bus_wdata, pin_in;
    logic [2:0] bus_bit_idx;
    logic [7:0] rd_data, pin_out, pin_oe, pin_pu;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0] m_lat, m_im, m_om, m_s1, m_s2;
    logic [7:0] rd_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_octet i_gpio_octet (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_bit(bus_bit),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_bit_idx(bus_bit_idx),
        .bus_bit_val(bus_bit_val), .rmw_read(rmw_read), .pullup_off(pullup_off),
        .pin_in(pin_in), .rd_data(rd_data), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    function automatic logic [7:0] exp_rd(input logic [1:0] sel, input logic rmw);
        case (sel)
            2'b00:   return rmw ? m_lat : (m_s2 & m_im);
            2'b01:   return m_im;
            2'b10:   return m_om;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_oe();
        return m_om | ~m_lat;
    endfunction

    function automatic logic [7:0] exp_out();
        return m_om & m_lat;
    endfunction

    function automatic logic [7:0] exp_pu(input logic off);
        return m_im & {8{~off}} & ~(exp_oe() & ~exp_out());
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_write(input logic wr, input logic bt, input logic [1:0] sel,
                               input logic [7:0] wd, input logic [2:0] idx, input logic bv);
        logic [7:0] tgt;
        case (sel)
            2'b00:   tgt = m_lat;
            2'b01:   tgt = m_im;
            2'b10:   tgt = m_om;
            default: tgt = 8'h00;
        endcase
        if (wr) tgt = wd;
        else if (bt) tgt[idx] = bv;
        if (wr || bt) begin
            case (sel)
                2'b00:   m_lat = tgt;
                2'b01:   m_im  = tgt;
                2'b10:   m_om  = tgt;
                default: ;
            endcase
        end
    endtask

    task automatic do_cycle(input logic wr, input logic bt, input logic [1:0] sel,
                            input logic [7:0] wd, input logic [2:0] idx, input logic bv,
                            input logic rmw, input logic [7:0] pins, input logic off);
        string rtag;
        @(negedge clk);
        bus_wr = wr; bus_bit = bt; bus_sel = sel; bus_wdata = wd;
        bus_bit_idx = idx; bus_bit_val = bv; rmw_read = rmw;
        pin_in = pins; pullup_off = off;
        #1;
        if (sel == 2'b00) rtag = rmw ? "R7 rmw read" : "R5 R6 pin read";
        else if (sel == 2'b11) rtag = "R11 reserved read";
        else rtag = "R2 mode read";
        rd_seen = rd_data;
        chk(rd_data, exp_rd(sel, rmw), rtag);
        chk(pin_oe, exp_oe(), "R8 R9 oe");
        chk(pin_out, exp_out(), "R8 R9 out");
        chk(pin_pu, exp_pu(off), "R10 pullup");
        @(posedge clk);
        model_write(wr, bt, sel, wd, idx, bv);
        m_s2 = m_s1;
        m_s1 = pins;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: requirement all, actual hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] rmw_val;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; bus_wr = 0; bus_bit = 0; bus_sel = 0; bus_wdata = 0;
        bus_bit_idx = 0; bus_bit_val = 0; rmw_read = 0; pullup_off = 0; pin_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_lat = 8'hFF; m_im = 8'hFF; m_om = 8'h00; m_s1 = 8'h00; m_s2 = 8'h00;

        // R1: reset state through the normal read path
        do_cycle(0, 0, 2'b01, 8'h00, 0, 0, 0, 8'h00, 0);
        chk(rd_seen, 8'hFF, "R1 input mode reset");
        do_cycle(0, 0, 2'b10, 8'h00, 0, 0, 0, 8'h00, 0);
        chk(rd_seen, 8'h00, "R1 output mode reset");
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 1, 8'h00, 0);
        chk(rd_seen, 8'hFF, "R1 latch reset");
        chk(pin_oe, 8'h00, "R1 R8 released after reset");

        // R2: byte write to output mode
        do_cycle(1, 0, 2'b10, 8'h0F, 0, 0, 0, 8'h00, 0);
        do_cycle(0, 0, 2'b10, 8'h00, 0, 0, 0, 8'h00, 0);
        chk(rd_seen, 8'h0F, "R2 byte write");

        // R3: bit clear on latch
        do_cycle(0, 1, 2'b00, 8'h00, 3'd6, 0, 0, 8'h00, 0);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 1, 8'h00, 0);
        chk(rd_seen, 8'hBF, "R3 bit clear");

        // R4: byte and bit write collide
        do_cycle(1, 1, 2'b00, 8'hA5, 3'd0, 0, 1, 8'h00, 0);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 1, 8'h00, 0);
        chk(rd_seen, 8'hA5, "R4 byte wins");

        // R11: reserved select writes nothing
        do_cycle(1, 0, 2'b11, 8'h3C, 0, 0, 0, 8'h00, 0);
        do_cycle(0, 1, 2'b11, 8'h00, 3'd2, 1, 0, 8'h00, 0);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 1, 8'h00, 0);
        chk(rd_seen, 8'hA5, "R11 latch untouched");

        // R5/R7/R8: open-drain pin 3 latch 1, pulled low externally
        do_cycle(1, 0, 2'b10, 8'h00, 0, 0, 0, 8'hF7, 0);
        do_cycle(1, 0, 2'b00, 8'hFF, 0, 0, 0, 8'hF7, 0);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 0, 8'hF7, 0);
        chk(rd_seen, 8'hF7, "R5 pin read shows external low");
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 1, 8'hF7, 0);
        rmw_val = rd_seen;
        chk(rmw_val, 8'hFF, "R7 rmw read keeps latch");
        do_cycle(1, 0, 2'b00, rmw_val, 0, 0, 0, 8'hF7, 0);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 1, 8'hF7, 0);
        chk(rd_seen, 8'hFF, "R7 write-back preserves latch");
        chk(pin_oe, 8'h00, "R8 all released");

        // R5: synchronizer latency of two edges
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 0, 8'h5A, 0);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 0, 8'h5A, 0);
        chk(rd_seen, 8'hF7, "R5 one edge still old");
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 0, 8'h5A, 0);
        chk(rd_seen, 8'h5A, "R5 two edges new");

        // R6: analog pins read zero
        do_cycle(1, 0, 2'b01, 8'h0F, 0, 0, 0, 8'hFF, 0);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 0, 8'hFF, 0);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 0, 8'hFF, 0);
        chk(rd_seen, 8'h0F, "R6 analog reads zero");
        chk(pin_pu, 8'h0F, "R10 analog pullup off");

        // R9/R10: push-pull with latch 0, pullups disabled globally
        do_cycle(1, 0, 2'b10, 8'hFF, 0, 0, 0, 8'hFF, 0);
        do_cycle(1, 0, 2'b00, 8'hF0, 0, 0, 0, 8'hFF, 1);
        do_cycle(0, 0, 2'b00, 8'h00, 0, 0, 0, 8'hFF, 1);
        chk(pin_oe, 8'hFF, "R9 push-pull enabled");
        chk(pin_out, 8'hF0, "R9 push-pull level");
        chk(pin_pu, 8'h00, "R10 global disable");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            do_cycle(r[2:0] == 3'd0, r[5:3] < 3'd2, r[7:6], $urandom, r[10:8],
                     r[11], r[12], $urandom, r[15:13] == 3'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule